// File: doc/BRIEF.md
# Dual-Target Microprogram Address Sequencer

This block chooses the next control-memory address in a microprogrammed control unit. Each microinstruction names two successors: a target taken when its selected condition holds and a target taken when it does not. No incrementer exists, so the program never falls through to the next word. When a new machine instruction begins, a start strobe loads an entry address formed from the opcode instead.

The current control-memory address (CMAR) is a register driven out of the block. The control memory sits outside the block. It returns the addressed microinstruction word, whose control field the block passes straight through as the control vector. The condition is picked from a small set of status flags by a select code inside the word. Code 0 stands for a condition that is always true.

The word layout, from the least significant bit up, is: false target `[ADDR_W-1:0]`, true target `[2*ADDR_W-1:ADDR_W]`, select code (`SEL_W` bits), then the control field (`CTRL_W` bits). With the defaults this is bits 9:0, 19:10, 22:20 and 38:23.

Top module: `dual_addr_useq`

## Requirements
- R1: While reset is asserted (rst_n low), and for the two clock edges after rst_n rises, cmar_o is 0.
- R2: When start_i is high at a clock edge, cmar_o after that edge equals opcode_i with two zero bits appended below it ({opcode_i, 2'b00}).
- R3: start_i takes priority over the select code and the flags. The entry address is loaded even when the current word would branch elsewhere.
- R4: With start_i low and select code 0, the true target (bits 19:10) is loaded whatever the flags are, and the false target has no effect.
- R5: With start_i low and select code k in 1..FLAG_W, if flags_i[k-1] is 1 the true target is loaded.
- R6: With start_i low and select code k in 1..FLAG_W, if flags_i[k-1] is 0 the false target (bits 9:0) is loaded.
- R7: Select codes above FLAG_W (5 to 7 with the defaults) count as false, so the false target is loaded.
- R8: ctrl_o equals bits 38:23 of uword_i in the same cycle, with no register in the path.
- R9: No address is ever incremented. A word whose two targets both equal the current address holds cmar_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a new machine instruction: load the opcode entry address |
| opcode_i | input | 8 | Opcode of the instruction held in the instruction register |
| flags_i | input | 4 | Status flags that the select code chooses among |
| uword_i | input | 39 | Microinstruction read from control memory at cmar_o |
| cmar_o | output | 10 | Control memory address register |
| ctrl_o | output | 16 | Control field of the current microinstruction |

## Verification
The assertions assume that uword_i is the word stored at cmar_o and that start_i, opcode_i and flags_i are steady around each rising edge. The properties only compare the address loaded at one edge against the fields, flags and opcode seen at the edge before. The bench keeps its control memory as a plain array indexed by the block's own address output. It changes inputs only at falling edges and holds start_i high while the internal reset is being released, so the address stays defined. Random words cover all eight select codes, including the unused ones. The bench also writes directed words for self-loops, start during a branch, and the highest and lowest entry addresses.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    RT_ENTRY   = 2'd0,
    RT_TAKEN   = 2'd1,
    RT_FALLOFF = 2'd2
  } route_e;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
  parameter int FLAG_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              cond_o
);
  localparam int NCODE = 1 << SEL_W;

  logic [NCODE-1:0] cand;

  // code 0: always true; 1..FLAG_W: one flag each; rest: false
  for (genvar k = 0; k < NCODE; k++) begin : g_code
    if (k == 0) begin : g_always
      assign cand[k] = 1'b1;
    end else if (k <= FLAG_W) begin : g_flag
      assign cand[k] = flags_i[k-1];
    end else begin : g_unmapped
      assign cand[k] = 1'b0;
    end
  end

  assign cond_o = cand[sel_i];
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int OPC_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic              start_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              cond_i,
  input  logic [ADDR_W-1:0] true_addr_i,
  input  logic [ADDR_W-1:0] false_addr_i,
  output logic [ADDR_W-1:0] next_addr_o
);
  localparam int PAD_W = ADDR_W - OPC_W;

  route_e            route;
  logic [ADDR_W-1:0] entry_addr;

  assign entry_addr = {opcode_i, {PAD_W{1'b0}}};

  always_comb begin
    if (start_i)     route = RT_ENTRY;
    else if (cond_i) route = RT_TAKEN;
    else             route = RT_FALLOFF;
  end

  always_comb begin
    unique case (route)
      RT_ENTRY: next_addr_o = entry_addr;
      RT_TAKEN: next_addr_o = true_addr_i;
      default:  next_addr_o = false_addr_i;
    endcase
  end
endmodule

// File: rtl/useq_cmar_reg.sv
module useq_cmar_reg #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cmar_d,
  output logic [ADDR_W-1:0] cmar_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmar_q <= '0;
    else        cmar_q <= cmar_d;
  end
endmodule

// File: rtl/dual_addr_useq.sv
module dual_addr_useq #(
  parameter int CTRL_W = 16,
  parameter int OPC_W  = 8,
  parameter int ADDR_W = 10,
  parameter int FLAG_W = 4,
  parameter int SEL_W  = 3,
  localparam int WORD_W = CTRL_W + SEL_W + 2*ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [WORD_W-1:0] uword_i,
  output logic [ADDR_W-1:0] cmar_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam int F_LSB    = 0;
  localparam int T_LSB    = ADDR_W;
  localparam int SEL_LSB  = 2*ADDR_W;
  localparam int CTRL_LSB = SEL_LSB + SEL_W;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] f_addr;
  logic [ADDR_W-1:0] t_addr;
  logic [SEL_W-1:0]  sel;
  logic              cond;
  logic [ADDR_W-1:0] cmar_d;

  assign f_addr = uword_i[F_LSB +: ADDR_W];
  assign t_addr = uword_i[T_LSB +: ADDR_W];
  assign sel    = uword_i[SEL_LSB +: SEL_W];
  assign ctrl_o = uword_i[CTRL_LSB +: CTRL_W];

  useq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  useq_cond_mux #(.FLAG_W(FLAG_W), .SEL_W(SEL_W)) u_cond_mux (
    .flags_i (flags_i),
    .sel_i   (sel),
    .cond_o  (cond)
  );

  useq_next_addr #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_next_addr (
    .start_i      (start_i),
    .opcode_i     (opcode_i),
    .cond_i       (cond),
    .true_addr_i  (t_addr),
    .false_addr_i (f_addr),
    .next_addr_o  (cmar_d)
  );

  useq_cmar_reg #(.ADDR_W(ADDR_W)) u_cmar_reg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmar_d (cmar_d),
    .cmar_q (cmar_o)
  );
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int CTRL_W = 16,
  parameter int OPC_W  = 8,
  parameter int ADDR_W = 10,
  parameter int FLAG_W = 4,
  parameter int SEL_W  = 3,
  localparam int WORD_W = CTRL_W + SEL_W + 2*ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [WORD_W-1:0] uword_i,
  input logic [ADDR_W-1:0] cmar_o
);
  localparam int PAD_W = ADDR_W - OPC_W;

  logic [ADDR_W-1:0] f_a;
  logic [ADDR_W-1:0] t_a;
  logic [SEL_W-1:0]  s;
  logic              s_flag;
  logic              s_mapped;

  assign f_a = uword_i[0 +: ADDR_W];
  assign t_a = uword_i[ADDR_W +: ADDR_W];
  assign s   = uword_i[2*ADDR_W +: SEL_W];

  always_comb begin
    s_flag   = 1'b0;
    s_mapped = 1'b0;
    for (int k = 1; k <= FLAG_W; k++) begin
      if (int'(s) == k) begin
        s_flag   = flags_i[k-1];
        s_mapped = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (cmar_o == '0); // R1
    end
  end

  AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> cmar_o == {$past(opcode_i), {PAD_W{1'b0}}}); // R2

  AST_START_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && s != '0) |=> cmar_o != $past(t_a) || $past(t_a) == {$past(opcode_i), {PAD_W{1'b0}}}); // R3

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && s == '0) |=> cmar_o == $past(t_a)); // R4

  AST_FLAG_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && s_mapped && s_flag) |=> cmar_o == $past(t_a)); // R5

  AST_FLAG_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && s_mapped && !s_flag) |=> cmar_o == $past(f_a)); // R6

  AST_UNMAPPED_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && s != '0 && !s_mapped) |=> cmar_o == $past(f_a)); // R7

  AST_SELF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && t_a == cmar_o && f_a == cmar_o) |=> $stable(cmar_o)); // R9
endmodule

bind dual_addr_useq useq_chk #(
  .CTRL_W (CTRL_W),
  .OPC_W  (OPC_W),
  .ADDR_W (ADDR_W),
  .FLAG_W (FLAG_W),
  .SEL_W  (SEL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start_i  (start_i),
  .opcode_i (opcode_i),
  .flags_i  (flags_i),
  .uword_i  (uword_i),
  .cmar_o   (cmar_o)
);

// File: tb/dual_addr_useq_tb.sv
`timescale 1ns/1ps
module dual_addr_useq_tb;
  localparam int CW = 16, OW = 8, AW = 10, FW = 4, SW = 3;
  localparam int WW = CW + SW + 2*AW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [OW-1:0] opc;
  logic [FW-1:0] flg;
  logic [WW-1:0] uword;
  logic [AW-1:0] cmar;
  logic [CW-1:0] ctrl;

  logic [WW-1:0] cmem [DEPTH];
  logic [AW-1:0] exp_addr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign uword = cmem[cmar];

  dual_addr_useq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .opcode_i(opc),
    .flags_i(flg), .uword_i(uword), .cmar_o(cmar), .ctrl_o(ctrl)
  );

  function automatic logic [WW-1:0] mk(input logic [CW-1:0] c, input logic [SW-1:0] s,
                                       input logic [AW-1:0] t, input logic [AW-1:0] f);
    return {c, s, t, f};
  endfunction

  function automatic logic [AW-1:0] model_next(input logic [WW-1:0] w, input logic st,
                                               input logic [OW-1:0] op, input logic [FW-1:0] fl);
    logic [SW-1:0] s;
    s = w[2*AW +: SW];
    if (st) return {op, 2'b00};
    if (s == 0) return w[AW +: AW];
    if (int'(s) <= FW) return fl[int'(s)-1] ? w[AW +: AW] : w[AW-1:0];
    return w[AW-1:0];
  endfunction

  function automatic string tag_of(input logic [WW-1:0] w, input logic st,
                                   input logic [FW-1:0] fl, input logic [AW-1:0] cur);
    logic [SW-1:0] s;
    s = w[2*AW +: SW];
    if (st) return (s != 0) ? "R3" : "R2";
    if (w[AW +: AW] == cur && w[AW-1:0] == cur) return "R9";
    if (s == 0) return "R4";
    if (int'(s) > FW) return "R7";
    return fl[int'(s)-1] ? "R5" : "R6";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic step(input logic st, input logic [OW-1:0] op, input logic [FW-1:0] fl);
    logic [AW-1:0] nxt;
    string t;
    start = st; opc = op; flg = fl;
    #0.1;
    nxt = model_next(cmem[exp_addr], st, op, fl);
    t = tag_of(cmem[exp_addr], st, fl, exp_addr);
    @(negedge clk);
    exp_addr = nxt;
    chk(t, cmar, exp_addr);
    chk("R8", ctrl, cmem[exp_addr][WW-1 -: CW]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    start = 1'b1; opc = '0; flg = '0;
    rst_n = 1'b0;
    #0.5;
    exp_addr = '0;
    chk("R1", cmar, 0);
    repeat (2) @(negedge clk);
    chk("R1", cmar, 0);
    chk("R8", ctrl, cmem[0][WW-1 -: CW]);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", cmar, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b1; opc = '0; flg = '0; exp_addr = '0;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) cmem[i] = {$urandom, $urandom};
    do_reset();

    // R2: entry address from opcode
    step(1'b1, 8'h5A, 4'h0);
    // R4: always-true select ignores flags and the false field
    cmem[10'h168] = mk(16'hA5A5, 3'd0, 10'h3FF, 10'h001);
    step(1'b0, 8'h00, 4'h0);
    // R5: select 2 looks at flags[1]
    cmem[10'h3FF] = mk(16'h1234, 3'd2, 10'h010, 10'h020);
    step(1'b0, 8'h00, 4'b0010);
    // R6: select 4 looks at flags[3], low
    cmem[10'h010] = mk(16'h0F0F, 3'd4, 10'h0C0, 10'h040);
    step(1'b0, 8'h00, 4'b0111);
    // R7: unmapped select 6 is false although all flags set
    cmem[10'h040] = mk(16'hBEEF, 3'd6, 10'h2AA, 10'h055);
    step(1'b0, 8'h00, 4'b1111);
    // R9: self loop holds the address
    cmem[10'h055] = mk(16'h7777, 3'd1, 10'h055, 10'h055);
    step(1'b0, 8'h00, 4'b0001);
    step(1'b0, 8'h00, 4'b0000);
    // R3: start wins over a taken branch
    cmem[10'h055] = mk(16'h7777, 3'd1, 10'h123, 10'h055);
    step(1'b1, 8'hFF, 4'b0001);
    // R4: always-true select with zero true target
    cmem[10'h3FC] = mk(16'h0001, 3'd0, 10'h000, 10'h3FF);
    step(1'b0, 8'h00, 4'hF);

    for (int n = 0; n < 400; n++)
      step(($urandom % 8) == 0, 8'($urandom), 4'($urandom));

    do_reset(); // R1 mid-run
    for (int n = 0; n < 100; n++)
      step(($urandom % 6) == 0, 8'($urandom), 4'($urandom));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule